// File: doc/BRIEF.md
# Card Presence Debounce and Interrupt Generator

This block sits between the two card-detect switch inputs of a smart card connector and the host controller. It accepts one detect line that signals a card by going low and one that signals a card by going high, so either a normally-open or a normally-closed connector can be wired. It synchronizes both lines and merges them into one raw presence signal. Insertion is accepted only after a programmable number of consecutive clock cycles of detection. Removal is reported as soon as the synchronizer lets it through.

The block also tracks whether a card session is open and drives one active-low interrupt level for the host. Outside a session the interrupt is a presence indicator: high with a debounced card, low without one. Supply undervoltage pulls it low in the same cycle, whatever the state. Inside a session the interrupt acts as a fault flag. A fault, a card removal or an undervoltage requests an immediate deactivation from the sequencer. The interrupt is then held low until the sequencer reports that the deactivation is done and the host has raised its session command again.

Top module: `card_presence_irq`

## Requirements
- R1: The raw presence is true when `det_lo_n` is 0 or `det_hi` is 1 (or both); either line alone is enough.
- R2: `card_present_o` rises only after DEB_CYCLES consecutive synchronized samples of raw presence. It becomes 1 exactly SYNC_STAGES + DEB_CYCLES rising edges after the detect inputs start showing a card.
- R3: A loss of detection lasting one cycle or more, before the debounce completes, restarts the count from zero.
- R4: When detection is lost, `card_present_o` falls SYNC_STAGES rising edges later, with no debounce.
- R5: Outside a session, `irq_n_o` equals `card_present_o` AND NOT `uv_i`. It is 0 whenever no debounced card is present.
- R6: `uv_i`=1 forces `irq_n_o` to 0 in the same cycle. Outside a session it returns to 1 once `uv_i` is 0 and a card is still present.
- R7: A session opens only on a high-to-low transition of `sess_cmd_n` while `card_present_o`=1 and `uv_i`=0. A level that is already low does not open one. Outside a session `fault_i` has no effect on either output.
- R8: During a session, `fault_i`=1 drives `irq_n_o` to 0 in the same cycle. `fault_i`, `uv_i` or a card removal asserts `deact_req_o` one rising edge after it is seen.
- R9: After a fault-caused deactivation, `irq_n_o` stays 0 until `deact_done_i` has been seen and `sess_cmd_n` is 1. It then shows card presence again.
- R10: Raising `sess_cmd_n` during a fault-free session asserts `deact_req_o` on the next edge while `irq_n_o` stays 1. `deact_req_o` drops on the edge that samples `deact_done_i`.
- R11: After reset `card_present_o`, `irq_n_o` and `deact_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| det_lo_n | input | 1 | Detect line, card present when 0 (asynchronous) |
| det_hi | input | 1 | Detect line, card present when 1 (asynchronous) |
| sess_cmd_n | input | 1 | Host session command, active low, synchronous |
| fault_i | input | 1 | Merged fault from supply, overload and thermal monitors |
| uv_i | input | 1 | Controller-side supply undervoltage |
| deact_done_i | input | 1 | Pulse from the sequencer when deactivation is complete |
| card_present_o | output | 1 | Debounced card presence for the sequencer |
| deact_req_o | output | 1 | Deactivation request to the sequencer, held until done |
| irq_n_o | output | 1 | Active-low interrupt level for the host |

## Verification
All four detect-line combinations are applied to show that the merge accepts either polarity and rejects only the fully absent pattern. A sweep places a one-cycle dropout after every possible partial run length. This tells a counter that restarts apart from one that merely pauses or one that fires early, and it pins the exact edge of assertion. Session sequences cover several paths: a fault with the command still low, an undervoltage, a removal, a host-requested close, and a command lowered before a card exists. Between them they separate the latched fault flag from plain presence reporting and edge-triggered session start from level-triggered.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DEACT  = 2'd2,
    ST_HOLD   = 2'd3
  } sess_state_e;
endpackage

// File: rtl/cpi_rst_sync.sv
module cpi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cpi_detect_sync.sv
module cpi_detect_sync #(
  parameter int unsigned          LINES   = 2,
  parameter int unsigned          STAGES  = 2,
  parameter logic [LINES-1:0]     IDLE_LV = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] sync_out
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    always_comb begin
      ff_d = {ff_q[STAGES-2:0], async_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{IDLE_LV[g]}};
      else        ff_q <= ff_d;
    end

    assign sync_out[g] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/cpi_debounce.sv
module cpi_debounce #(
  parameter int unsigned DEB_CYCLES = 400000,
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic stable_out
);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_q, acc_d;
  logic          upd_en;

  // Timer runs only while a card is seen but not yet accepted.
  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (!raw_in) begin
      cnt_d = '0;
      acc_d = 1'b0;
    end else if (!acc_q) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        acc_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = raw_in | acc_q | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // Loss of detection bypasses the accepted flag at once.
  assign stable_out = acc_q & raw_in;
endmodule

// File: rtl/cpi_session_fsm.sv
module cpi_session_fsm
  import cpi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        present,
  input  logic        sess_cmd_n,
  input  logic        fault_i,
  input  logic        uv_i,
  input  logic        deact_done_i,
  output sess_state_e state_o,
  output logic        deact_req_o,
  output logic        irq_n_o
);
  sess_state_e st_q, st_d;
  logic        flt_q, flt_d;
  logic        cmd_prev_q;
  logic        open_evt;
  logic        kill_evt;

  assign open_evt = cmd_prev_q & ~sess_cmd_n & present & ~uv_i;
  assign kill_evt = ~present | fault_i | uv_i;

  always_comb begin
    st_d  = st_q;
    flt_d = flt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (open_evt) st_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (kill_evt) begin
          st_d  = ST_DEACT;
          flt_d = 1'b1;
        end else if (sess_cmd_n) begin
          st_d = ST_DEACT;
        end
      end
      ST_DEACT: begin
        if (deact_done_i) begin
          if (sess_cmd_n) begin
            st_d  = ST_IDLE;
            flt_d = 1'b0;
          end else begin
            st_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (sess_cmd_n) begin
          st_d  = ST_IDLE;
          flt_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      flt_q      <= 1'b0;
      cmd_prev_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      flt_q      <= flt_d;
      cmd_prev_q <= sess_cmd_n;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:   irq_n_o = present & ~uv_i;
      ST_ACTIVE: irq_n_o = present & ~uv_i & ~fault_i;
      default:   irq_n_o = present & ~uv_i & ~flt_q;
    endcase
  end

  assign deact_req_o = (st_q == ST_DEACT);
  assign state_o     = st_q;
endmodule

// File: rtl/card_presence_irq.sv
module card_presence_irq
  import cpi_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 400000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_lo_n,
  input  logic det_hi,
  input  logic sess_cmd_n,
  input  logic fault_i,
  input  logic uv_i,
  input  logic deact_done_i,
  output logic card_present_o,
  output logic deact_req_o,
  output logic irq_n_o
);
  localparam int unsigned NLINES = 2;
  // Bit 1 idles high (active-low line), bit 0 idles low.
  localparam logic [NLINES-1:0] LINE_IDLE = 2'b10;

  logic              rst_n_int;
  logic [NLINES-1:0] det_sync;
  logic              raw_present;
  sess_state_e       state;

  cpi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cpi_detect_sync #(
    .LINES   (NLINES),
    .STAGES  (SYNC_STAGES),
    .IDLE_LV (LINE_IDLE)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({det_lo_n, det_hi}),
    .sync_out (det_sync)
  );

  assign raw_present = ~det_sync[1] | det_sync[0];

  cpi_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .raw_in     (raw_present),
    .stable_out (card_present_o)
  );

  cpi_session_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .present      (card_present_o),
    .sess_cmd_n   (sess_cmd_n),
    .fault_i      (fault_i),
    .uv_i         (uv_i),
    .deact_done_i (deact_done_i),
    .state_o      (state),
    .deact_req_o  (deact_req_o),
    .irq_n_o      (irq_n_o)
  );
endmodule

// File: rtl/card_presence_irq_chk.sv
module card_presence_irq_chk
  import cpi_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 400000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        det_lo_n,
  input logic        det_hi,
  input logic        sess_cmd_n,
  input logic        fault_i,
  input logic        uv_i,
  input logic        raw_present,
  input sess_state_e state,
  input logic        card_present_o,
  input logic        deact_req_o,
  input logic        irq_n_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 2);
  logic [CW-1:0] run_q;
  logic          absent_in;

  assign absent_in = det_lo_n & ~det_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      run_q <= '0;
    else if (!raw_present)           run_q <= '0;
    else if (run_q != CW'(DEB_CYCLES)) run_q <= run_q + 1'b1;
  end

  a_r2_debounce_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_present_o) |-> (run_q >= CW'(DEB_CYCLES - 1)));

  a_r4_removal_fast: assert property (@(posedge clk) disable iff (!rst_n)
    $past(absent_in, 2) |-> !card_present_o);

  a_r5_no_card_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    !card_present_o |-> !irq_n_o);

  a_r6_uv_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> !irq_n_o);

  a_r8_fault_deact: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && fault_i) |=> deact_req_o);

  a_r10_host_close: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && sess_cmd_n) |=> deact_req_o);
endmodule

bind card_presence_irq card_presence_irq_chk #(.DEB_CYCLES(DEB_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .det_lo_n       (det_lo_n),
  .det_hi         (det_hi),
  .sess_cmd_n     (sess_cmd_n),
  .fault_i        (fault_i),
  .uv_i           (uv_i),
  .raw_present    (raw_present),
  .state          (state),
  .card_present_o (card_present_o),
  .deact_req_o    (deact_req_o),
  .irq_n_o        (irq_n_o)
);

// File: tb/card_presence_irq_tb_top.sv
module card_presence_irq_tb_top;
  localparam int DEB  = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic det_lo_n, det_hi, sess_cmd_n, fault_i, uv_i, deact_done_i;
  logic card_present_o, deact_req_o, irq_n_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  card_presence_irq #(.DEB_CYCLES(DEB), .SYNC_STAGES(SYNC)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .det_lo_n       (det_lo_n),
    .det_hi         (det_hi),
    .sess_cmd_n     (sess_cmd_n),
    .fault_i        (fault_i),
    .uv_i           (uv_i),
    .deact_done_i   (deact_done_i),
    .card_present_o (card_present_o),
    .deact_req_o    (deact_req_o),
    .irq_n_o        (irq_n_o)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic card(input logic on);
    det_lo_n = ~on;
    det_hi   = 1'b0;
  endtask

  task automatic insert_debounced();
    card(1'b1);
    step(SYNC + DEB + 1);
  endtask

  task automatic finish_deact();
    sess_cmd_n   = 1'b1;
    deact_done_i = 1'b1;
    step(1);
    deact_done_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; det_lo_n = 1'b1; det_hi = 1'b0; sess_cmd_n = 1'b1;
    fault_i = 1'b0; uv_i = 1'b0; deact_done_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(3);
    // R11: reset state
    chk(card_present_o, 1'b0, "R11");
    chk(irq_n_o, 1'b0, "R11");
    chk(deact_req_o, 1'b0, "R11");

    // R1: every detect combination, expected presence = !lo_n | hi
    for (int c = 0; c < 4; c++) begin
      det_lo_n = 1'b1; det_hi = 1'b0;
      step(SYNC + 1);
      det_lo_n = c[0]; det_hi = c[1];
      step(SYNC + DEB + 1);
      chk(card_present_o, ~c[0] | c[1], "R1");
      chk(irq_n_o, ~c[0] | c[1], "R5");
    end

    // R2: exact edge of acceptance
    card(1'b0); step(SYNC + 1);
    card(1'b1);
    step(SYNC + DEB - 1);
    chk(card_present_o, 1'b0, "R2");
    step(1);
    chk(card_present_o, 1'b1, "R2");

    // R4: removal after SYNC edges
    card(1'b0);
    step(SYNC - 1);
    chk(card_present_o, 1'b1, "R4");
    step(1);
    chk(card_present_o, 1'b0, "R4");
    chk(irq_n_o, 1'b0, "R5");

    // R3: one-cycle dropout after every partial run length restarts the count
    for (int k = 1; k < DEB; k++) begin
      card(1'b0); step(SYNC + 1);
      card(1'b1); step(k);
      card(1'b0); step(1);
      chk(card_present_o, 1'b0, "R3");
      card(1'b1);
      step(SYNC + DEB - 1);
      chk(card_present_o, 1'b0, "R3");
      step(1);
      chk(card_present_o, 1'b1, "R3");
    end

    // R6: undervoltage outside a session
    uv_i = 1'b1; #1;
    chk(irq_n_o, 1'b0, "R6");
    step(2);
    uv_i = 1'b0; #1;
    chk(irq_n_o, 1'b1, "R6");
    step(1);

    // R7: fault ignored outside a session
    fault_i = 1'b1; step(1);
    chk(irq_n_o, 1'b1, "R7");
    chk(deact_req_o, 1'b0, "R7");
    fault_i = 1'b0; step(1);

    // R8/R9: fault in session, command still low when done arrives
    sess_cmd_n = 1'b0; step(1);
    chk(deact_req_o, 1'b0, "R8");
    fault_i = 1'b1; #1;
    chk(irq_n_o, 1'b0, "R8");
    step(1);
    chk(deact_req_o, 1'b1, "R8");
    fault_i = 1'b0; step(1);
    chk(irq_n_o, 1'b0, "R9");
    deact_done_i = 1'b1; step(1);
    deact_done_i = 1'b0;
    chk(deact_req_o, 1'b0, "R9");
    chk(irq_n_o, 1'b0, "R9");
    step(2);
    chk(irq_n_o, 1'b0, "R9");
    sess_cmd_n = 1'b1; step(1);
    chk(irq_n_o, 1'b1, "R9");

    // R10: host-requested close keeps irq high
    sess_cmd_n = 1'b0; step(1);
    sess_cmd_n = 1'b1; step(1);
    chk(deact_req_o, 1'b1, "R10");
    chk(irq_n_o, 1'b1, "R10");
    deact_done_i = 1'b1; step(1);
    deact_done_i = 1'b0;
    chk(deact_req_o, 1'b0, "R10");
    chk(irq_n_o, 1'b1, "R10");

    // R8: undervoltage in session latches the fault flag
    sess_cmd_n = 1'b0; step(1);
    uv_i = 1'b1; #1;
    chk(irq_n_o, 1'b0, "R6");
    step(1);
    chk(deact_req_o, 1'b1, "R8");
    uv_i = 1'b0; step(1);
    chk(irq_n_o, 1'b0, "R9");
    finish_deact();
    chk(irq_n_o, 1'b1, "R9");
    chk(deact_req_o, 1'b0, "R9");

    // R8: removal in session
    sess_cmd_n = 1'b0; step(1);
    card(1'b0);
    step(SYNC);
    chk(irq_n_o, 1'b0, "R8");
    step(1);
    chk(deact_req_o, 1'b1, "R8");
    finish_deact();

    // R7: command lowered before a card exists does not open a session
    sess_cmd_n = 1'b0; step(2);
    insert_debounced();
    chk(card_present_o, 1'b1, "R7");
    fault_i = 1'b1; step(1);
    chk(deact_req_o, 1'b0, "R7");
    chk(irq_n_o, 1'b1, "R7");
    fault_i = 1'b0;
    sess_cmd_n = 1'b1; step(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule